// File: doc/BRIEF.md
# Half-Operand Modifier Operand Fetch

This block is the operand-fetch stage of a pipeline that performs arithmetic on partitioned registers. It contains a register file of 2^A entries, each N = 2^K bits wide, with one write port. On each request it reads two source registers, A and B. Each operand then passes through its own modifier before it leaves for the execution unit.

A modifier views the operand as a row of fields of the current width n = 2^k. It can replace every field with the upper half or the lower half of that field. The chosen half sits zero-extended in the low n/2 bits of the field. The field width arrives as a one-hot vector that is shared with the execute stage. Each operand has its own pair of high/low flags, so either operand, both or neither can be modified.

The modified operands are registered. They appear one cycle after the request, together with a valid flag. A write to the address being read in the same cycle is forwarded to the read.

Top module: `hom_operand_fetch`

## Requirements
- R1: After reset, `op_valid` is 0, `op_a` and `op_b` are 0, and every register in the file reads as 0.
- R2: A request with `rd_req`=1 at a clock edge sets `op_valid`=1 and updates `op_a`/`op_b` at that edge. The updated operands are available one cycle after the request is presented. `op_valid` is 0 after an edge without a request.
- R3: With hi=1, lo=0 and field width 2^k (`width_oh[k]`=1, k≥1), each field of the operand becomes its upper half. That half sits in the lower half of the field and the upper half of the field is zero.
- R4: With hi=0, lo=1 and field width 2^k (k≥1), each field of the operand keeps its lower half and its upper half is cleared to zero.
- R5: With hi=lo (both 0 or both 1), the operand passes unchanged.
- R6: At field width 1 (`width_oh[0]`=1), the operand passes unchanged for every hi/lo setting.
- R7: The A and B modifiers are independent. Each uses only its own flags, and both use the shared width.
- R8: A write whose address equals a read address in the same cycle delivers the written data to that read, before any modifier is applied. The data is also stored.
- R9: While `rd_req` is 0, `op_a` and `op_b` keep their last values, even if a register file write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | A | Write address |
| wr_data | input | N | Write data |
| rd_req | input | 1 | Operand fetch request |
| a_addr | input | A | Source A register address |
| a_hi | input | 1 | Source A high-half modifier |
| a_lo | input | 1 | Source A low-half modifier |
| b_addr | input | A | Source B register address |
| b_hi | input | 1 | Source B high-half modifier |
| b_lo | input | 1 | Source B low-half modifier |
| width_oh | input | K+1 | One-hot field width, bit k means 2^k-bit fields |
| op_valid | output | 1 | Operands valid |
| op_a | output | N | Modified operand A |
| op_b | output | N | Modified operand B |

## Verification
A wrong mask for one field width damages only the reads at that width with a modifier set. Every width is therefore crossed with every hi/lo pair on both operands. The error shows on `op_a`/`op_b` one cycle after the offending request. A corrupted register or a missed write-forward shows on the next read of that address. A stray update of the output registers shows during idle cycles, as a change while `rd_req` is low.

// File: rtl/hom_operand_fetch.sv
module hom_operand_fetch #(
  parameter int ADDR_W = 3,
  parameter int LOG_N  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [(1<<LOG_N)-1:0] wr_data,
  input  logic                rd_req,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic                a_hi,
  input  logic                a_lo,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic                b_hi,
  input  logic                b_lo,
  input  logic [LOG_N:0]      width_oh,
  output logic                op_valid,
  output logic [(1<<LOG_N)-1:0] op_a,
  output logic [(1<<LOG_N)-1:0] op_b
);
  localparam int N    = 1 << LOG_N;
  localparam int REGS = 1 << ADDR_W;

  logic [N-1:0] regs [REGS];
  logic [N-1:0] raw_a, raw_b;

  // bit i is in the lower half of its 2^k field when bit k-1 of i is clear
  function automatic logic [N-1:0] low_mask(input int k);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = ((i >> (k - 1)) & 1) == 0;
    return m;
  endfunction

  function automatic logic [N-1:0] modify(input logic [N-1:0] x, input logic h,
                                          input logic l, input logic [LOG_N:0] w);
    logic [N-1:0] r;
    r = x;
    if (h != l)
      for (int k = 1; k <= LOG_N; k++)
        if (w[k]) r = h ? ((x >> (1 << (k - 1))) & low_mask(k)) : (x & low_mask(k));
    return r;
  endfunction

  assign raw_a = (wr_en && wr_addr == a_addr) ? wr_data : regs[a_addr];
  assign raw_b = (wr_en && wr_addr == b_addr) ? wr_data : regs[b_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_a     <= '0;
      op_b     <= '0;
    end else begin
      op_valid <= rd_req;
      if (rd_req) begin
        op_a <= modify(raw_a, a_hi, a_lo, width_oh);
        op_b <= modify(raw_b, b_hi, b_lo, width_oh);
      end
    end
  end

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> op_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !op_valid);
  p_width_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $onehot(width_oh));
  p_pass_equal_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && (a_hi == a_lo) |=> op_a == $past(raw_a));
  p_width1_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && width_oh[0] |=> op_a == $past(raw_a) && op_b == $past(raw_b));
  p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && a_hi && !a_lo && width_oh[LOG_N] |=>
      op_a[N-1:N/2] == '0 && op_a[N/2-1:0] == $past(raw_a[N-1:N/2]));
  p_full_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && b_lo && !b_hi && width_oh[LOG_N] |=>
      op_b[N-1:N/2] == '0 && op_b[N/2-1:0] == $past(raw_b[N/2-1:0]));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(op_a) && $stable(op_b));
endmodule

// File: tb/sim_hom_operand_fetch.sv
`timescale 1ns/1ps
module sim_hom_operand_fetch;
  localparam int AW = 3;
  localparam int LN = 5;
  localparam int NB = 1 << LN;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_req = 0;
  logic [AW-1:0] wr_addr = '0, a_addr = '0, b_addr = '0;
  logic [NB-1:0] wr_data = '0;
  logic a_hi = 0, a_lo = 0, b_hi = 0, b_lo = 0;
  logic [LN:0] width_oh = 1;
  logic op_valid;
  logic [NB-1:0] op_a, op_b;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [NB-1:0] shadow [1<<AW];

  always #2.5 clk = ~clk;

  hom_operand_fetch #(.ADDR_W(AW), .LOG_N(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .a_addr(a_addr), .a_hi(a_hi), .a_lo(a_lo),
    .b_addr(b_addr), .b_hi(b_hi), .b_lo(b_lo), .width_oh(width_oh),
    .op_valid(op_valid), .op_a(op_a), .op_b(op_b));

  function automatic logic [NB-1:0] ref_mod(input logic [NB-1:0] x, input logic h,
                                            input logic l, input int k);
    logic [NB-1:0] r;
    int n, half;
    if (k == 0 || h == l) return x;
    n = 1 << k; half = n / 2; r = '0;
    for (int f = 0; f < NB / n; f++)
      for (int b = 0; b < half; b++)
        r[f*n + b] = h ? x[f*n + half + b] : x[f*n + b];
    return r;
  endfunction

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int addr, input logic [NB-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    shadow[addr] = d;
  endtask

  task automatic do_read(input int aa, input logic ah, input logic al,
                         input int ba, input logic bh, input logic bl, input int k);
    @(negedge clk);
    rd_req = 1; a_addr = AW'(aa); b_addr = AW'(ba);
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl; width_oh = (LN+1)'(1) << k;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic t_reset;
    check("R1 op_valid after reset", {31'b0, op_valid}, '0);
    check("R1 op_a after reset", op_a, '0);
    check("R1 op_b after reset", op_b, '0);
    do_read(0, 0, 0, 7, 0, 0, 0);
    check("R1 reg0 reads zero", op_a, '0);
    check("R1 reg7 reads zero", op_b, '0);
  endtask

  task automatic t_write_read;
    do_write(2, 32'hA5C3_0F96);
    do_write(5, 32'h1234_5678);
    do_read(2, 0, 0, 5, 0, 0, 3);
    check("R2 op_valid after request", {31'b0, op_valid}, 32'd1);
    check("R2 op_a data", op_a, 32'hA5C3_0F96);
    check("R2 op_b data", op_b, 32'h1234_5678);
    @(negedge clk);
    check("R2 op_valid drops", {31'b0, op_valid}, '0);
  endtask

  task automatic t_all_modes;
    logic [NB-1:0] pats [8];
    pats[0] = 32'hA5C3_0F96; pats[1] = 32'h1234_5678; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h8000_0001; pats[4] = 32'hDEAD_BEEF; pats[5] = 32'h0F0F_F0F0;
    pats[6] = 32'h6996_C33C; pats[7] = 32'h5555_AAAA;
    for (int i = 0; i < 8; i++) do_write(i, pats[i]);
    for (int k = 0; k <= LN; k++)
      for (int m = 0; m < 16; m++) begin
        int ra, rb;
        logic ah, al, bh, bl;
        ra = (k + m) % 8; rb = (k * 3 + m + 1) % 8;
        ah = m[0]; al = m[1]; bh = m[2]; bl = m[3];
        do_read(ra, ah, al, rb, bh, bl, k);
        if (k == 0)
          check("R6 width1 passthrough A", op_a, shadow[ra]);
        else if (ah == al)
          check("R5 equal flags A", op_a, ref_mod(shadow[ra], ah, al, k));
        else if (ah)
          check("R3 high half A", op_a, ref_mod(shadow[ra], ah, al, k));
        else
          check("R4 low half A", op_a, ref_mod(shadow[ra], ah, al, k));
        check("R7 independent B", op_b, ref_mod(shadow[rb], bh, bl, k));
      end
  endtask

  task automatic t_forward;
    @(negedge clk);
    wr_en = 1; wr_addr = 3; wr_data = 32'hCAFE_1234;
    rd_req = 1; a_addr = 3; b_addr = 4; a_hi = 1; a_lo = 0; b_hi = 0; b_lo = 0;
    width_oh = 6'b01_0000;
    @(negedge clk);
    wr_en = 0; rd_req = 0; shadow[3] = 32'hCAFE_1234;
    check("R8 forwarded write to read", op_a, ref_mod(32'hCAFE_1234, 1, 0, 4));
    check("R8 other port unaffected", op_b, shadow[4]);
    do_read(3, 0, 0, 3, 0, 1, 2);
    check("R8 forwarded data stored", op_a, 32'hCAFE_1234);
    check("R8 stored low half", op_b, ref_mod(32'hCAFE_1234, 0, 1, 2));
  endtask

  task automatic t_idle_hold;
    logic [NB-1:0] ha, hb;
    do_read(1, 1, 0, 6, 0, 1, 1);
    ha = op_a; hb = op_b;
    do_write(1, 32'h0BAD_F00D);
    @(negedge clk);
    check("R9 op_a holds when idle", op_a, ha);
    check("R9 op_b holds when idle", op_b, hb);
    check("R9 op_valid low when idle", {31'b0, op_valid}, '0);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_read;
    t_all_modes;
    t_forward;
    t_idle_hold;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule